// File: doc/BRIEF.md
# Always-On Power-Mode Sequencer

This block lives in the always-on domain beside a USB OTG-style link controller and decides how much of the controller stays alive. It runs in three modes. In full operation everything is clocked and powered. In partial power down, entered while the bus is suspended or asleep, the switchable logic keeps its supply, its clocks are gated and the remaining logic moves to a slow clock of roughly 32 kHz, so that wake-up stays short. In idle, entered when the session is not valid or software asks for it, the switchable domain loses its supply entirely.

Going into idle runs an ordered handshake: clocks stop, retention registers save, isolation clamps the domain boundary, and the power switch is asked to turn off. Coming back reverses it: power on, restore, release isolation, restart clocks, then hand control back to the link core. Whenever the core is not in control, the sequencer owns the interrupt line and ignores the core's interrupt. A wake from the remote side or the application raises a wake interrupt and starts power-up. A wake that arrives part-way through a power-down reverses the sequence from the step it has reached. Each step that waits on an acknowledge is timed against a programmable limit, and an expired limit raises an error interrupt.

Top module: `aon_pwr_seq`

## Requirements
- R1: After reset, clocks are enabled, the slow clock is not selected, save, restore, isolation and power-off request are low, `irqOut` is low, `coreOwns` is 1 and `mode` is 0.
- R2: In full mode with `busSuspend` or `busSleep` high and no idle condition, the next cycle shows mode 1 with clocks gated, the slow clock selected, and power-off, isolation and save low. It returns to mode 0 with clocks running and the fast clock selected one cycle after both suspend and sleep are low or a wake event is seen.
- R3: An idle condition (`sessionValid` low or `swDownReq` high) in mode 0 or 1 makes the next cycle show mode 3, clocks gated, the slow clock selected and `saveStb` high. The power-off request is never high while clocks are enabled or isolation is low.
- R4: `saveStb` stays high until `retDone` is seen, after which `isoEn` rises while `saveStb` falls. `pwrOffReq` rises one cycle later, and mode 2 follows one cycle after `pwrOn` goes low.
- R5: A wake event (`remoteWake` or `appWake`) in mode 2 drops `pwrOffReq` and sets a pending wake interrupt on `irqOut` in the next cycle. A wake accepted in mode 1 or during power-down sets the same interrupt.
- R6: Power-up order: once `pwrOn` is high, `restoreStb` is high until `retDone`. Then isolation drops while clocks stay gated, and one cycle later clocks run on the fast clock with mode 0 and `coreOwns` 1.
- R7: `coreIrq` reaches `irqOut` only while `coreOwns` is 1, which is only in mode 0. In every other mode it has no effect on `irqOut`.
- R8: A wake while `saveStb` is waiting drops `saveStb` and restarts clocks one cycle later with no restore. A wake while isolation is being applied releases it and restarts clocks one cycle later. A wake while waiting for power-off drops `pwrOffReq` and continues with the restore steps of R6.
- R9: With `ackTimeout` = N > 0, a handshake step whose acknowledge is still absent on the Nth clock after entry sets a pending error interrupt on that edge, and the step keeps waiting. N = 0 disables the check.
- R10: `irqClear` high at a clock edge clears both pending interrupts (a new event on the same edge wins).
- R11: `mode` encodes 0 = full, 1 = partial, 2 = idle (domain off), 3 = sequencing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rstN | input | 1 | Active-low asynchronous reset |
| swDownReq | input | 1 | Software request for idle |
| busSuspend | input | 1 | Bus suspended |
| busSleep | input | 1 | Bus in sleep state |
| sessionValid | input | 1 | Session valid; low requests idle |
| remoteWake | input | 1 | Wake event from the remote device |
| appWake | input | 1 | Wake event from the application |
| pwrOn | input | 1 | Switchable domain supply is up |
| retDone | input | 1 | Save or restore finished |
| ackTimeout | input | TMR_W | Handshake timeout in cycles, 0 disables |
| coreIrq | input | 1 | Interrupt from the switchable domain |
| irqClear | input | 1 | Clear pending wake and error interrupts |
| clkEn | output | 1 | Clock enable to the switchable domain |
| slowClkSel | output | 1 | Select the slow clock |
| saveStb | output | 1 | Retention save request |
| restoreStb | output | 1 | Retention restore request |
| isoEn | output | 1 | Isolation clamp enable |
| pwrOffReq | output | 1 | Power switch off request |
| irqOut | output | 1 | Interrupt to software |
| coreOwns | output | 1 | Link core owns events and interrupts |
| mode | output | 2 | Current power mode (R11) |
| seqState | output | 4 | Raw sequencer state, for observation |

## Verification
A sequencer stuck in a wrong state shows up at the control outputs on the very next clock edge. Every transition moves its registered strobes on the same edge, so a skipped or reordered step shows as isolation, save or power-off asserted one cycle early or late, or `mode` sitting at a value its inputs do not justify. A wrong owner shows as `coreIrq` leaking onto `irqOut` while idle. A broken timer shows as the error interrupt appearing one edge before or after the Nth clock. Each scenario therefore samples one cycle after every stimulus edge rather than only at the end of a sequence.

// File: rtl/aon_pwr_pkg.sv
package aon_pwr_pkg;

  typedef enum logic [3:0] {
    S_FULL    = 4'd0,
    S_PART    = 4'd1,
    S_DN_SAVE = 4'd2,
    S_DN_ISO  = 4'd3,
    S_DN_PWR  = 4'd4,
    S_OFF     = 4'd5,
    S_UP_PWR  = 4'd6,
    S_UP_RST  = 4'd7,
    S_UP_CLK  = 4'd8
  } seqState_e;

  // one-cycle commands from control to the datapath registers
  typedef struct packed {
    logic clkStop;
    logic clkRun;
    logic saveSet;
    logic saveClr;
    logic restoreSet;
    logic restoreClr;
    logic isoSet;
    logic isoClr;
    logic pwrDown;
    logic pwrUp;
    logic ownTake;
    logic ownGive;
    logic tmrClr;
    logic tmrRun;
    logic wakeEvt;
  } seqStrobes_t;

  localparam logic [1:0] MODE_FULL = 2'd0;
  localparam logic [1:0] MODE_PART = 2'd1;
  localparam logic [1:0] MODE_IDLE = 2'd2;
  localparam logic [1:0] MODE_SEQ  = 2'd3;

  function automatic logic [1:0] modeOf(seqState_e s);
    case (s)
      S_FULL:  return MODE_FULL;
      S_PART:  return MODE_PART;
      S_OFF:   return MODE_IDLE;
      default: return MODE_SEQ;
    endcase
  endfunction

endpackage

// File: rtl/aon_pwr_ctrl.sv
module aon_pwr_ctrl
  import aon_pwr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        swDownReq,
  input  logic        busSuspend,
  input  logic        busSleep,
  input  logic        sessionValid,
  input  logic        remoteWake,
  input  logic        appWake,
  input  logic        pwrOn,
  input  logic        retDone,
  output seqStrobes_t sb,
  output seqState_e   state
);

  logic      offCond;
  logic      gateCond;
  logic      wake;
  seqState_e nxt;

  assign offCond  = !sessionValid || swDownReq;
  assign gateCond = busSuspend || busSleep;
  assign wake     = remoteWake || appWake;

  always_comb begin
    nxt = state;
    sb  = '0;
    case (state)
      S_FULL, S_PART: begin
        if (offCond) begin
          nxt = S_DN_SAVE;
          sb.clkStop = 1'b1;
          sb.ownTake = 1'b1;
          sb.saveSet = 1'b1;
          sb.tmrClr  = 1'b1;
        end else if (state == S_FULL && gateCond) begin
          nxt = S_PART;
          sb.clkStop = 1'b1;
          sb.ownTake = 1'b1;
        end else if (state == S_PART && (wake || !gateCond)) begin
          nxt = S_FULL;
          sb.clkRun  = 1'b1;
          sb.ownGive = 1'b1;
          sb.wakeEvt = wake;
        end
      end
      S_DN_SAVE: begin
        if (wake) begin
          nxt = S_UP_CLK;
          sb.saveClr = 1'b1;
          sb.wakeEvt = 1'b1;
        end else if (retDone) begin
          nxt = S_DN_ISO;
          sb.saveClr = 1'b1;
          sb.isoSet  = 1'b1;
        end else begin
          sb.tmrRun = 1'b1;
        end
      end
      S_DN_ISO: begin
        if (wake) begin
          nxt = S_UP_CLK;
          sb.isoClr  = 1'b1;
          sb.wakeEvt = 1'b1;
        end else begin
          nxt = S_DN_PWR;
          sb.pwrDown = 1'b1;
          sb.tmrClr  = 1'b1;
        end
      end
      S_DN_PWR: begin
        if (wake) begin
          nxt = S_UP_PWR;
          sb.pwrUp   = 1'b1;
          sb.tmrClr  = 1'b1;
          sb.wakeEvt = 1'b1;
        end else if (!pwrOn) begin
          nxt = S_OFF;
        end else begin
          sb.tmrRun = 1'b1;
        end
      end
      S_OFF: begin
        if (wake) begin
          nxt = S_UP_PWR;
          sb.pwrUp   = 1'b1;
          sb.tmrClr  = 1'b1;
          sb.wakeEvt = 1'b1;
        end
      end
      S_UP_PWR: begin
        if (pwrOn) begin
          nxt = S_UP_RST;
          sb.restoreSet = 1'b1;
          sb.tmrClr     = 1'b1;
        end else begin
          sb.tmrRun = 1'b1;
        end
      end
      S_UP_RST: begin
        if (retDone) begin
          nxt = S_UP_CLK;
          sb.restoreClr = 1'b1;
          sb.isoClr     = 1'b1;
        end else begin
          sb.tmrRun = 1'b1;
        end
      end
      S_UP_CLK: begin
        nxt = S_FULL;
        sb.clkRun  = 1'b1;
        sb.ownGive = 1'b1;
      end
      default: nxt = S_FULL;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_FULL;
    else       state <= nxt;
  end

  // R11
  legal_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    state inside {S_FULL, S_PART, S_DN_SAVE, S_DN_ISO, S_DN_PWR,
                  S_OFF, S_UP_PWR, S_UP_RST, S_UP_CLK});

  // R4
  off_needs_dn_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_OFF && $past(state) != S_OFF) |-> $past(state) == S_DN_PWR && !$past(pwrOn));

endmodule

// File: rtl/aon_pwr_dp.sv
module aon_pwr_dp
  import aon_pwr_pkg::*;
#(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobes_t      sb,
  input  logic [TMR_W-1:0] ackTimeout,
  input  logic             coreIrq,
  input  logic             irqClear,
  output logic             clkEn,
  output logic             slowClkSel,
  output logic             saveStb,
  output logic             restoreStb,
  output logic             isoEn,
  output logic             pwrOffReq,
  output logic             coreOwns,
  output logic             irqOut
);

  localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

  logic [TMR_W-1:0] tmrCnt;
  logic             errEvt;
  logic             wakeIrq;
  logic             errIrq;

  assign errEvt = sb.tmrRun && (ackTimeout != '0) && (tmrCnt == ackTimeout - ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkEn      <= 1'b1;
      slowClkSel <= 1'b0;
      saveStb    <= 1'b0;
      restoreStb <= 1'b0;
      isoEn      <= 1'b0;
      pwrOffReq  <= 1'b0;
      coreOwns   <= 1'b1;
    end else begin
      if (sb.clkStop)    begin clkEn <= 1'b0; slowClkSel <= 1'b1; end
      if (sb.clkRun)     begin clkEn <= 1'b1; slowClkSel <= 1'b0; end
      if (sb.saveSet)    saveStb    <= 1'b1;
      if (sb.saveClr)    saveStb    <= 1'b0;
      if (sb.restoreSet) restoreStb <= 1'b1;
      if (sb.restoreClr) restoreStb <= 1'b0;
      if (sb.isoSet)     isoEn      <= 1'b1;
      if (sb.isoClr)     isoEn      <= 1'b0;
      if (sb.pwrDown)    pwrOffReq  <= 1'b1;
      if (sb.pwrUp)      pwrOffReq  <= 1'b0;
      if (sb.ownTake)    coreOwns   <= 1'b0;
      if (sb.ownGive)    coreOwns   <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrCnt <= '0;
    end else if (sb.tmrClr) begin
      tmrCnt <= '0;
    end else if (sb.tmrRun && tmrCnt != ackTimeout) begin
      tmrCnt <= tmrCnt + ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeIrq <= 1'b0;
      errIrq  <= 1'b0;
    end else begin
      if (sb.wakeEvt)     wakeIrq <= 1'b1;
      else if (irqClear)  wakeIrq <= 1'b0;
      if (errEvt)         errIrq  <= 1'b1;
      else if (irqClear)  errIrq  <= 1'b0;
    end
  end

  assign irqOut = wakeIrq || errIrq || (coreIrq && coreOwns);

  // R4
  save_restore_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(saveStb && restoreStb));

  // R9
  err_from_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errIrq) |-> $past(sb.tmrRun));

endmodule

// File: rtl/aon_pwr_seq.sv
module aon_pwr_seq
  import aon_pwr_pkg::*;
#(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             swDownReq,
  input  logic             busSuspend,
  input  logic             busSleep,
  input  logic             sessionValid,
  input  logic             remoteWake,
  input  logic             appWake,
  input  logic             pwrOn,
  input  logic             retDone,
  input  logic [TMR_W-1:0] ackTimeout,
  input  logic             coreIrq,
  input  logic             irqClear,
  output logic             clkEn,
  output logic             slowClkSel,
  output logic             saveStb,
  output logic             restoreStb,
  output logic             isoEn,
  output logic             pwrOffReq,
  output logic             irqOut,
  output logic             coreOwns,
  output logic [1:0]       mode,
  output logic [3:0]       seqState
);

  seqStrobes_t sb;
  seqState_e   state;

  aon_pwr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .swDownReq(swDownReq), .busSuspend(busSuspend),
    .busSleep(busSleep), .sessionValid(sessionValid), .remoteWake(remoteWake),
    .appWake(appWake), .pwrOn(pwrOn), .retDone(retDone), .sb(sb), .state(state)
  );

  aon_pwr_dp #(.TMR_W(TMR_W)) u_dp (
    .clk(clk), .rstN(rstN), .sb(sb), .ackTimeout(ackTimeout), .coreIrq(coreIrq),
    .irqClear(irqClear), .clkEn(clkEn), .slowClkSel(slowClkSel), .saveStb(saveStb),
    .restoreStb(restoreStb), .isoEn(isoEn), .pwrOffReq(pwrOffReq),
    .coreOwns(coreOwns), .irqOut(irqOut)
  );

  assign mode     = modeOf(state);
  assign seqState = state;

  // R3
  off_after_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    pwrOffReq |-> !clkEn && isoEn);

  // R4
  iso_before_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwrOffReq) |-> $past(isoEn));

  // R6
  iso_clear_at_clk_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkEn) |-> !isoEn && !restoreStb);

  // R2
  partial_powered_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_PART) |-> !pwrOffReq && !isoEn && slowClkSel && !clkEn);

  // R7
  owner_only_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    coreOwns |-> mode == MODE_FULL);

endmodule

// File: tb/aon_pwr_seq_test.sv
module aon_pwr_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int TMR_W      = 8;

  logic clk = 1'b0;
  logic rstN, swDownReq, busSuspend, busSleep, sessionValid, remoteWake, appWake;
  logic pwrOn, retDone, coreIrq, irqClear;
  logic [TMR_W-1:0] ackTimeout;
  logic clkEn, slowClkSel, saveStb, restoreStb, isoEn, pwrOffReq, irqOut, coreOwns;
  logic [1:0] mode;
  logic [3:0] seqState;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aon_pwr_seq #(.TMR_W(TMR_W)) uut (
    .clk(clk), .rstN(rstN), .swDownReq(swDownReq), .busSuspend(busSuspend),
    .busSleep(busSleep), .sessionValid(sessionValid), .remoteWake(remoteWake),
    .appWake(appWake), .pwrOn(pwrOn), .retDone(retDone), .ackTimeout(ackTimeout),
    .coreIrq(coreIrq), .irqClear(irqClear), .clkEn(clkEn), .slowClkSel(slowClkSel),
    .saveStb(saveStb), .restoreStb(restoreStb), .isoEn(isoEn), .pwrOffReq(pwrOffReq),
    .irqOut(irqOut), .coreOwns(coreOwns), .mode(mode), .seqState(seqState)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clearIrq();
    irqClear = 1'b1;
    step();
    irqClear = 1'b0;
  endtask

  task automatic testReset();
    chk("R1", "clkEn", clkEn, 1);
    chk("R1", "slowClkSel", slowClkSel, 0);
    chk("R1", "save/restore", {saveStb, restoreStb}, 0);
    chk("R1", "iso/pwrOff", {isoEn, pwrOffReq}, 0);
    chk("R1", "irqOut", irqOut, 0);
    chk("R1", "coreOwns", coreOwns, 1);
    chk("R11", "mode", mode, 0);
  endtask

  task automatic testPartial();
    busSuspend = 1'b1;
    step();
    chk("R2", "mode partial", mode, 1);
    chk("R2", "clk gated", clkEn, 0);
    chk("R2", "slow sel", slowClkSel, 1);
    chk("R2", "no pwr/iso/save", {pwrOffReq, isoEn, saveStb}, 0);
    coreIrq = 1'b1;
    step();
    chk("R7", "core irq ignored in partial", irqOut, 0);
    coreIrq = 1'b0;
    busSuspend = 1'b0;
    step();
    chk("R2", "resume mode", mode, 0);
    chk("R2", "resume clocks", {clkEn, slowClkSel}, 2);
    coreIrq = 1'b1;
    #1;
    chk("R7", "core irq passes in full", irqOut, 1);
    coreIrq = 1'b0;
    busSleep = 1'b1;
    step();
    chk("R2", "sleep mode", mode, 1);
    remoteWake = 1'b1;
    busSleep = 1'b0;
    step();
    remoteWake = 1'b0;
    chk("R2", "wake exits partial", mode, 0);
    chk("R5", "wake irq from partial", irqOut, 1);
    clearIrq();
    chk("R10", "irq cleared", irqOut, 0);
  endtask

  task automatic testPowerCycle();
    sessionValid = 1'b0;
    step();
    chk("R3", "mode seq", mode, 3);
    chk("R3", "clk gated slow", {clkEn, slowClkSel}, 1);
    chk("R3", "save high", saveStb, 1);
    chk("R3", "iso/pwr low", {isoEn, pwrOffReq}, 0);
    retDone = 1'b1;
    step();
    retDone = 1'b0;
    chk("R4", "save dropped", saveStb, 0);
    chk("R4", "iso set", isoEn, 1);
    chk("R4", "pwr not yet", pwrOffReq, 0);
    step();
    chk("R4", "pwr off req", pwrOffReq, 1);
    pwrOn = 1'b0;
    step();
    chk("R4", "idle mode", mode, 2);
    coreIrq = 1'b1;
    step();
    chk("R7", "core irq ignored idle", irqOut, 0);
    coreIrq = 1'b0;
    step();
    chk("R11", "idle holds", mode, 2);
    sessionValid = 1'b1;
    remoteWake = 1'b1;
    step();
    remoteWake = 1'b0;
    chk("R5", "pwr on req", pwrOffReq, 0);
    chk("R5", "wake irq", irqOut, 1);
    chk("R11", "mode seq on wake", mode, 3);
    clearIrq();
    pwrOn = 1'b1;
    step();
    chk("R6", "restore", restoreStb, 1);
    chk("R6", "iso kept, clk gated", {isoEn, clkEn}, 2);
    retDone = 1'b1;
    step();
    retDone = 1'b0;
    chk("R6", "restore done", restoreStb, 0);
    chk("R6", "iso released first", {isoEn, clkEn}, 0);
    step();
    chk("R6", "clocks run fast", {clkEn, slowClkSel}, 2);
    chk("R6", "full mode", mode, 0);
    chk("R6", "core owns", coreOwns, 1);
  endtask

  task automatic testAbortEarly();
    swDownReq = 1'b1;
    step();
    swDownReq = 1'b0;
    chk("R8", "save started", saveStb, 1);
    appWake = 1'b1;
    step();
    appWake = 1'b0;
    chk("R8", "save aborted", saveStb, 0);
    chk("R8", "no restore, clk still off", {restoreStb, clkEn}, 0);
    step();
    chk("R8", "clk back", clkEn, 1);
    chk("R8", "full after abort", mode, 0);
    chk("R5", "wake irq abort", irqOut, 1);
    clearIrq();
  endtask

  task automatic testAbortLate();
    swDownReq = 1'b1;
    step();
    swDownReq = 1'b0;
    retDone = 1'b1;
    step();
    retDone = 1'b0;
    step();
    chk("R8", "pwr req before abort", pwrOffReq, 1);
    remoteWake = 1'b1;
    step();
    remoteWake = 1'b0;
    chk("R8", "pwr req dropped", pwrOffReq, 0);
    chk("R8", "iso held", isoEn, 1);
    step();
    chk("R8", "restore after late abort", restoreStb, 1);
    retDone = 1'b1;
    step();
    retDone = 1'b0;
    chk("R8", "iso released", isoEn, 0);
    step();
    chk("R8", "full after late abort", mode, 0);
    clearIrq();
    swDownReq = 1'b1;
    step();
    swDownReq = 1'b0;
    retDone = 1'b1;
    step();
    retDone = 1'b0;
    chk("R8", "iso stage", isoEn, 1);
    appWake = 1'b1;
    step();
    appWake = 1'b0;
    chk("R8", "iso abort no pwr", {isoEn, pwrOffReq}, 0);
    step();
    chk("R8", "full after iso abort", {mode, clkEn}, 1);
    clearIrq();
  endtask

  task automatic testTimeout();
    ackTimeout = 8'd5;
    swDownReq = 1'b1;
    step();
    swDownReq = 1'b0;
    repeat (4) step();
    chk("R9", "no err before limit", irqOut, 0);
    step();
    chk("R9", "err at limit", irqOut, 1);
    chk("R9", "step still waiting", saveStb, 1);
    clearIrq();
    chk("R10", "err cleared", irqOut, 0);
    step();
    chk("R9", "err raised once", irqOut, 0);
    appWake = 1'b1;
    step();
    appWake = 1'b0;
    step();
    clearIrq();
    ackTimeout = 8'd0;
    swDownReq = 1'b1;
    step();
    swDownReq = 1'b0;
    repeat (30) step();
    chk("R9", "zero disables", irqOut, 0);
    appWake = 1'b1;
    step();
    appWake = 1'b0;
    step();
    clearIrq();
    chk("R9", "back to full", mode, 0);
    ackTimeout = 8'd20;
  endtask

  initial begin
    rstN = 1'b0; swDownReq = 1'b0; busSuspend = 1'b0; busSleep = 1'b0;
    sessionValid = 1'b1; remoteWake = 1'b0; appWake = 1'b0; pwrOn = 1'b1;
    retDone = 1'b0; coreIrq = 1'b0; irqClear = 1'b0; ackTimeout = 8'd20;
    repeat (3) step();
    rstN = 1'b1;
    step();
    testReset();
    testPartial();
    testPowerCycle();
    testAbortEarly();
    testAbortLate();
    testTimeout();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule